// File: doc/BRIEF.md
# Tournament Direction Chooser

This block sits beside two conditional-branch direction predictors. One is a per-branch predictor (local or bimodal) and the other works from global history. For each branch it decides which of the two directions to trust. It keeps a table of small two-bit chooser entries. The table is indexed either by the global history register or by a slice of the branch address, and a parameter picks which. A prediction request carries the history, the address and both component directions. Two cycles later the block returns the chosen direction, a flag telling which component it used, and the table index it read.

When the branch resolves, the pipeline hands back the index that was returned with the prediction, both component predictions and the real outcome. The block then rewrites that entry. There are two update policies, selected by parameter:

- **Counter policy.** Each entry is a saturating counter. It moves toward the local side when only the local component was right, and toward the global side when only the global component was right.
- **Flag policy.** Each entry stores two flags, one for each component, recording whether that component was right at its latest resolution. The local side wins only when local was right and global was wrong.

After reset the table is swept to its start value, one entry per cycle. While the sweep runs, requests are ignored.

Top module: `tourney_chooser`

## Requirements
- R1: The table index is `pred_ghr_i` when the history source is selected. When the address source is selected it is `pred_pc_i[IDX_LSB +: HIST_W]`. The index used is returned on `pred_idx_o` with the prediction.
- R2: After reset is released, `ready_o` stays low for exactly 2^HIST_W cycles and then stays high. Prediction and resolution requests presented while `ready_o` is low are ignored, and no `pred_valid_o` pulse results from them.
- R3: After the sweep, every counter-policy entry reads 01 and every flag-policy entry reads 00. In both cases the global direction is chosen.
- R4: Counter policy: when the local prediction matched the outcome and the global one did not, the entry increments, saturating at 11.
- R5: Counter policy: when the global prediction matched the outcome and the local one did not, the entry decrements, saturating at 00.
- R6: Counter policy: when both components were right, or both were wrong, the entry is unchanged.
- R7: Counter policy: the local direction is chosen exactly when bit 1 of the entry is set.
- R8: Flag policy: each resolution overwrites the entry with bit 1 = (local prediction matched outcome) and bit 0 = (global prediction matched outcome).
- R9: Flag policy: the local direction is chosen only when the entry equals 2'b10; otherwise the global direction is chosen.
- R10: A request accepted at a clock edge gives a one-cycle `pred_valid_o` pulse after the second edge. With the pulse, `pred_dir_o` equals the component direction (captured with the request) that `pred_use_local_o` names.
- R11: Resolutions to the same entry on consecutive cycles compound, each one acting on the result of the previous one. A resolution is visible to any prediction accepted two or more edges after the resolution was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_o | output | 1 | Table sweep finished; requests are accepted |
| pred_req_i | input | 1 | Prediction request |
| pred_ghr_i | input | HIST_W | Global history for the request |
| pred_pc_i | input | PC_W | Branch address for the request |
| pred_local_i | input | 1 | Local/bimodal component direction (1 = taken) |
| pred_global_i | input | 1 | Global component direction (1 = taken) |
| pred_valid_o | output | 1 | Prediction result valid (one-cycle pulse) |
| pred_dir_o | output | 1 | Chosen direction |
| pred_use_local_o | output | 1 | 1 when the local component was chosen |
| pred_idx_o | output | HIST_W | Table index the prediction read |
| upd_valid_i | input | 1 | Resolution request |
| upd_idx_i | input | HIST_W | Index returned earlier with the prediction |
| upd_local_i | input | 1 | Local component prediction of the resolved branch |
| upd_global_i | input | 1 | Global component prediction of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |

## Verification
The hardest case to reach from the ports is a resolution that reads an entry in the very cycle its previous resolution is being written back. This happens only when two resolutions to the same index arrive on back-to-back cycles. The bench drives a counter to 00 with spaced resolutions and then sends two local-wins resolutions on consecutive cycles. It then checks that the counter has reached 10, which selects local; a stale read would leave 01, which selects global. Around this directed case, every entry of a 16-entry configuration of both policies receives a sweep of outcome combinations. After each round every entry is predicted and compared against an arithmetic model.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic {
    POL_COUNTER = 1'b0,
    POL_FLAGS   = 1'b1
  } policy_e;

  typedef enum logic {
    SRC_HISTORY = 1'b0,
    SRC_ADDRESS = 1'b1
  } idx_src_e;

  localparam int ENTRY_W = 2;
  typedef logic [ENTRY_W-1:0] entry_t;

  // Start value written by the post-reset sweep
  function automatic entry_t start_entry(policy_e pol);
    return (pol == POL_COUNTER) ? 2'b01 : 2'b00;
  endfunction

endpackage

// File: rtl/tc_index.sv
module tc_index #(
  parameter int HIST_W  = 12,
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter tc_pkg::idx_src_e SRC = tc_pkg::SRC_HISTORY
) (
  input  logic [HIST_W-1:0] ghr_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [HIST_W-1:0] idx_o
);

  // Inputs not used by the selected source are folded here
  logic unused_src_bits;
  assign unused_src_bits = ^{ghr_i, pc_i};

  generate
    if (SRC == tc_pkg::SRC_HISTORY) begin : g_hist
      assign idx_o = ghr_i;
    end else begin : g_addr
      assign idx_o = pc_i[IDX_LSB +: HIST_W];
    end
  endgenerate

endmodule

// File: rtl/tc_policy.sv
module tc_policy #(
  parameter tc_pkg::policy_e POLICY = tc_pkg::POL_COUNTER
) (
  input  tc_pkg::entry_t entry_i,        // entry read for a prediction
  output logic           choose_local_o,
  input  tc_pkg::entry_t upd_old_i,      // entry value before resolution
  input  logic           lc_i,           // local matched outcome
  input  logic           gc_i,           // global matched outcome
  output tc_pkg::entry_t upd_new_o
);

  generate
    if (POLICY == tc_pkg::POL_COUNTER) begin : g_counter
      logic unused_low;
      assign unused_low     = entry_i[0];
      assign choose_local_o = entry_i[1];

      always_comb begin
        upd_new_o = upd_old_i;
        if (lc_i && !gc_i && (upd_old_i != 2'b11)) begin
          upd_new_o = upd_old_i + 2'd1;
        end else if (!lc_i && gc_i && (upd_old_i != 2'b00)) begin
          upd_new_o = upd_old_i - 2'd1;
        end
      end
    end else begin : g_flags
      logic unused_old;
      assign unused_old     = ^upd_old_i;
      // bit 1: local was right, bit 0: global was right
      assign choose_local_o = entry_i[1] && !entry_i[0];
      assign upd_new_o      = {lc_i, gc_i};
    end
  endgenerate

endmodule

// File: rtl/tc_table.sv
module tc_table #(
  parameter int IDX_W = 12,
  parameter tc_pkg::entry_t START_VAL = 2'b01
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 ready_o,
  input  logic [IDX_W-1:0]     rd_a_idx_i,
  output tc_pkg::entry_t       rd_a_q_o,
  input  logic [IDX_W-1:0]     rd_b_idx_i,
  output tc_pkg::entry_t       rd_b_q_o,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  tc_pkg::entry_t       wr_data_i
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  tc_pkg::entry_t mem [DEPTH];

  logic [IDX_W-1:0] sweep_ptr;
  logic             ready_q;

  // Post-reset sweep: one entry per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_ptr <= '0;
      ready_q   <= 1'b0;
    end else if (!ready_q) begin
      sweep_ptr <= sweep_ptr + 1'b1;
      if (sweep_ptr == LAST_IDX) begin
        ready_q <= 1'b1;
      end
    end
  end

  logic             mem_we;
  logic [IDX_W-1:0] mem_waddr;
  tc_pkg::entry_t   mem_wdata;

  always_comb begin
    mem_we    = wr_en_i;
    mem_waddr = wr_idx_i;
    mem_wdata = wr_data_i;
    if (!ready_q) begin
      mem_we    = 1'b1;
      mem_waddr = sweep_ptr;
      mem_wdata = START_VAL;
    end
  end

  // Single write port, no reset on the array
  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_waddr] <= mem_wdata;
    end
  end

  // Registered read ports, read-first with respect to the write
  always_ff @(posedge clk) begin
    rd_a_q_o <= mem[rd_a_idx_i];
    rd_b_q_o <= mem[rd_b_idx_i];
  end

  assign ready_o = ready_q;

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o); // R2

endmodule

// File: rtl/tourney_chooser.sv
module tourney_chooser #(
  parameter int HIST_W  = 12,
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter tc_pkg::idx_src_e IDX_SRC = tc_pkg::SRC_HISTORY,
  parameter tc_pkg::policy_e  POLICY  = tc_pkg::POL_COUNTER
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready_o,
  input  logic              pred_req_i,
  input  logic [HIST_W-1:0] pred_ghr_i,
  input  logic [PC_W-1:0]   pred_pc_i,
  input  logic              pred_local_i,
  input  logic              pred_global_i,
  output logic              pred_valid_o,
  output logic              pred_dir_o,
  output logic              pred_use_local_o,
  output logic [HIST_W-1:0] pred_idx_o,
  input  logic              upd_valid_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_local_i,
  input  logic              upd_global_i,
  input  logic              upd_taken_i
);

  localparam int IDX_W = HIST_W;
  localparam tc_pkg::entry_t START_VAL = tc_pkg::start_entry(POLICY);

  // ---------------- index selection ----------------
  logic [IDX_W-1:0] req_idx;

  tc_index #(
    .HIST_W (HIST_W),
    .PC_W   (PC_W),
    .IDX_LSB(IDX_LSB),
    .SRC    (IDX_SRC)
  ) u_index (
    .ghr_i (pred_ghr_i),
    .pc_i  (pred_pc_i),
    .idx_o (req_idx)
  );

  // ---------------- chooser table ----------------
  tc_pkg::entry_t   rd_a_q, rd_b_q;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  tc_pkg::entry_t   wr_data;

  tc_table #(
    .IDX_W    (IDX_W),
    .START_VAL(START_VAL)
  ) u_table (
    .clk        (clk),
    .rst        (rst),
    .ready_o    (ready_o),
    .rd_a_idx_i (req_idx),
    .rd_a_q_o   (rd_a_q),
    .rd_b_idx_i (upd_idx_i),
    .rd_b_q_o   (rd_b_q),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data)
  );

  // ---------------- prediction pipeline ----------------
  logic             s1_valid;
  logic             s1_local, s1_global;
  logic [IDX_W-1:0] s1_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_local  <= 1'b0;
      s1_global <= 1'b0;
      s1_idx    <= '0;
    end else begin
      s1_valid <= pred_req_i && ready_o;
      if (pred_req_i && ready_o) begin
        s1_local  <= pred_local_i;
        s1_global <= pred_global_i;
        s1_idx    <= req_idx;
      end
    end
  end

  // ---------------- resolution pipeline ----------------
  logic             u1_valid;
  logic [IDX_W-1:0] u1_idx;
  logic             u1_lc, u1_gc;
  logic             u1_fwd;
  tc_pkg::entry_t   u1_fwd_val;
  tc_pkg::entry_t   upd_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      u1_valid   <= 1'b0;
      u1_idx     <= '0;
      u1_lc      <= 1'b0;
      u1_gc      <= 1'b0;
      u1_fwd     <= 1'b0;
      u1_fwd_val <= '0;
    end else begin
      u1_valid   <= upd_valid_i && ready_o;
      u1_idx     <= upd_idx_i;
      u1_lc      <= (upd_local_i == upd_taken_i);
      u1_gc      <= (upd_global_i == upd_taken_i);
      // the write going out this edge is newer than what the RAM returns
      u1_fwd     <= wr_en && (wr_idx == upd_idx_i);
      u1_fwd_val <= wr_data;
    end
  end

  assign upd_old = u1_fwd ? u1_fwd_val : rd_b_q;

  // ---------------- policy ----------------
  logic choose_local;

  tc_policy #(
    .POLICY(POLICY)
  ) u_policy (
    .entry_i        (rd_a_q),
    .choose_local_o (choose_local),
    .upd_old_i      (upd_old),
    .lc_i           (u1_lc),
    .gc_i           (u1_gc),
    .upd_new_o      (wr_data)
  );

  assign wr_en  = u1_valid;
  assign wr_idx = u1_idx;

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid_o     <= 1'b0;
      pred_dir_o       <= 1'b0;
      pred_use_local_o <= 1'b0;
      pred_idx_o       <= '0;
    end else begin
      pred_valid_o <= s1_valid;
      if (s1_valid) begin
        pred_use_local_o <= choose_local;
        pred_dir_o       <= choose_local ? s1_local : s1_global;
        pred_idx_o       <= s1_idx;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $past(pred_req_i && ready_o, 2) |-> pred_valid_o); // R10

  AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (rst)
    pred_valid_o |-> $past(pred_req_i && ready_o, 2)); // R2

  AST_DIR_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (pred_valid_o && pred_use_local_o) |-> (pred_dir_o == $past(pred_local_i, 2))); // R10

  AST_DIR_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (pred_valid_o && !pred_use_local_o) |-> (pred_dir_o == $past(pred_global_i, 2))); // R10

  generate
    if (POLICY == tc_pkg::POL_COUNTER) begin : g_cnt_chk
      AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (u1_lc == u1_gc)) |-> (wr_data == upd_old)); // R6

      AST_CNT_TOP_SAT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && u1_lc && !u1_gc && (upd_old == 2'b11)) |-> (wr_data == 2'b11)); // R4

      AST_CNT_LOW_SAT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !u1_lc && u1_gc && (upd_old == 2'b00)) |-> (wr_data == 2'b00)); // R5

      AST_CNT_PICK: assert property (@(posedge clk) disable iff (rst)
        pred_valid_o |-> (pred_use_local_o == $past(rd_a_q[1]))); // R7
    end else begin : g_flag_chk
      AST_FLAG_PICK: assert property (@(posedge clk) disable iff (rst)
        pred_valid_o |-> (pred_use_local_o == ($past(rd_a_q) == 2'b10))); // R9
    end
  endgenerate

endmodule

// File: tb/tourney_chooser_tb.sv
module tourney_chooser_tb;

  localparam int HW    = 4;
  localparam int PW    = 8;
  localparam int DEPTH = 1 << HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic          req = 0, pl = 0, pg = 0;
  logic [HW-1:0] ghr = '0;
  logic [PW-1:0] pc = '0;
  logic          uv = 0, ul = 0, ug = 0, ut = 0;
  logic [HW-1:0] uidx = '0;

  logic          c_ready, c_valid, c_dir, c_loc;
  logic [HW-1:0] c_idx;
  logic          f_ready, f_valid, f_dir, f_loc;
  logic [HW-1:0] f_idx;

  tourney_chooser #(.HIST_W(HW), .PC_W(PW), .IDX_LSB(2),
    .IDX_SRC(tc_pkg::SRC_HISTORY), .POLICY(tc_pkg::POL_COUNTER)) u_dut (
    .clk(clk), .rst(rst), .ready_o(c_ready),
    .pred_req_i(req), .pred_ghr_i(ghr), .pred_pc_i(pc),
    .pred_local_i(pl), .pred_global_i(pg),
    .pred_valid_o(c_valid), .pred_dir_o(c_dir), .pred_use_local_o(c_loc), .pred_idx_o(c_idx),
    .upd_valid_i(uv), .upd_idx_i(uidx), .upd_local_i(ul), .upd_global_i(ug), .upd_taken_i(ut));

  tourney_chooser #(.HIST_W(HW), .PC_W(PW), .IDX_LSB(2),
    .IDX_SRC(tc_pkg::SRC_ADDRESS), .POLICY(tc_pkg::POL_FLAGS)) u_dut_flags (
    .clk(clk), .rst(rst), .ready_o(f_ready),
    .pred_req_i(req), .pred_ghr_i(ghr), .pred_pc_i(pc),
    .pred_local_i(pl), .pred_global_i(pg),
    .pred_valid_o(f_valid), .pred_dir_o(f_dir), .pred_use_local_o(f_loc), .pred_idx_o(f_idx),
    .upd_valid_i(uv), .upd_idx_i(uidx), .upd_local_i(ul), .upd_global_i(ug), .upd_taken_i(ut));

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int mc   [DEPTH];   // counter model
  int mf   [DEPTH];   // flag model
  int kind [DEPTH];   // last counter event: 3 reset, 4 inc, 5 dec, 6 hold

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic void model_update(input int i, input bit l, input bit g, input bit t);
    bit lc = (l == t);
    bit gc = (g == t);
    if (lc && !gc) begin
      if (mc[i] < 3) mc[i]++;
      kind[i] = 4;
    end else if (!lc && gc) begin
      if (mc[i] > 0) mc[i]--;
      kind[i] = 5;
    end else begin
      kind[i] = 6;
    end
    mf[i] = (int'(lc) << 1) | int'(gc);
  endfunction

  task automatic resolve(input int i, input bit l, input bit g, input bit t);
    @(negedge clk);
    uv = 1; uidx = HW'(i); ul = l; ug = g; ut = t;
    @(negedge clk);
    uv = 0;
    model_update(i, l, g, t);
  endtask

  task automatic predict(input int i, input bit l, input bit g, input int junk);
    bit exp_cl, exp_fl;
    @(negedge clk);
    req = 1; pl = l; pg = g;
    ghr = HW'(i);
    pc  = {2'(junk), HW'(i), 2'(junk + 1)};
    @(negedge clk);
    req = 0;
    chk("R10 no early valid", int'(c_valid), 0);
    @(negedge clk);
    chk("R10 valid pulse", int'(c_valid && f_valid), 1);
    chk("R1 history index", int'(c_idx), i);
    chk("R1 address index", int'(f_idx), i);
    exp_cl = (mc[i] >= 2);
    exp_fl = (mf[i] == 2);
    case (kind[i])
      3:       chk("R3 counter start choice", int'(c_loc), int'(exp_cl));
      4:       chk("R4 counter after local win", int'(c_loc), int'(exp_cl));
      5:       chk("R5 counter after global win", int'(c_loc), int'(exp_cl));
      default: chk("R6 counter after tie", int'(c_loc), int'(exp_cl));
    endcase
    chk("R7 counter direction", int'(c_dir), int'(exp_cl ? l : g));
    chk("R9 flag choice", int'(f_loc), int'(exp_fl));
    chk("R8 flag direction", int'(f_dir), int'(exp_fl ? l : g));
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int cycles;
    for (int i = 0; i < DEPTH; i++) begin
      mc[i] = 1; mf[i] = 0; kind[i] = 3;
    end

    repeat (3) @(negedge clk);
    chk("R2 ready low in reset", int'(c_ready || f_ready), 0);
    chk("R2 no valid in reset", int'(c_valid || f_valid), 0);

    // Release reset with a request held high: it must be ignored
    rst = 0; req = 1; uv = 1; uidx = '0; ul = 1; ug = 0; ut = 1;
    cycles = 0;
    while (!c_ready && cycles < DEPTH + 8) begin
      @(negedge clk);
      cycles++;
      if (c_valid || f_valid) chk("R2 request during sweep", 1, 0);
    end
    req = 0; uv = 0;
    chk("R2 sweep length", cycles, DEPTH);
    chk("R2 both ready", int'(f_ready), 1);
    @(negedge clk);
    chk("R2 ignored request no pulse", int'(c_valid || f_valid), 0);

    // R3: start values everywhere, both global directions
    for (int i = 0; i < DEPTH; i++) begin
      predict(i, 1'b1, 1'b0, i);
      predict(i, 1'b0, 1'b1, i + 1);
    end

    // R4/R5 saturation directed on entry 0
    for (int k = 0; k < 4; k++) resolve(0, 1'b1, 1'b0, 1'b1);
    chk("R4 saturated top", mc[0], 3);
    predict(0, 1'b0, 1'b1, 0);
    for (int k = 0; k < 5; k++) resolve(0, 1'b1, 1'b0, 1'b0);
    chk("R5 saturated bottom", mc[0], 0);
    predict(0, 1'b1, 1'b0, 2);
    resolve(0, 1'b1, 1'b0, 1'b1);   // 00 -> 01, still global
    predict(0, 1'b1, 1'b0, 3);

    // Sweep of outcome combinations over all entries
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        int code = (i * 5 + r * 3 + (i >> 2)) % 8;
        resolve(i, code[2], code[1], code[0]);
      end
      for (int i = 0; i < DEPTH; i++) begin
        int lg = (i + r) % 4;
        predict(i, lg[1], lg[0], r + i);
      end
    end

    // R11: back-to-back resolutions to the same entry
    for (int k = 0; k < 4; k++) resolve(3, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    uv = 1; uidx = HW'(3); ul = 1; ug = 0; ut = 1;
    @(negedge clk);
    ul = 0; ug = 1; ut = 0;          // local right again, global wrong
    @(negedge clk);
    uv = 0;
    model_update(3, 1'b1, 1'b0, 1'b1);
    model_update(3, 1'b0, 1'b1, 1'b0);
    chk("R11 model counter", mc[3], 2);
    predict(3, 1'b1, 1'b0, 1);
    chk("R11 back-to-back compounds", int'(c_loc), 1);
    resolve(3, 1'b1, 1'b0, 1'b1);
    predict(3, 1'b0, 1'b1, 2);
    chk("R11 counter after third step", int'(c_dir), 0);

    // R11 flag: second of two back-to-back writes wins
    @(negedge clk);
    uv = 1; uidx = HW'(5); ul = 1; ug = 1; ut = 1;
    @(negedge clk);
    ul = 1; ug = 0; ut = 1;
    @(negedge clk);
    uv = 0;
    model_update(5, 1'b1, 1'b1, 1'b1);
    model_update(5, 1'b1, 1'b0, 1'b1);
    predict(5, 1'b1, 1'b0, 0);
    chk("R11 flag last write wins", int'(f_loc), 1);

    finish_run();
  end

endmodule